// File: doc/BRIEF.md
# Dual-Lane Synchronous Serial Receiver

This block deserializes two serial data lanes, a primary and a secondary, that share one receive bit clock and one frame sync. The bit clock can come from a pin or from an internal divider of the system clock. The frame sync can also come from a pin or from an internal generator. When the clock or the sync is generated inside, the block drives the matching pin and raises its output enable. All pins are brought into the system clock domain through a short synchronizer. Data is sampled on the falling edge of the bit clock, so the transmitter is expected to change data on the rising edge.

A word starts on the sample edge where frame sync is seen high. It runs for the configured number of bits, most significant bit first. When it is complete, each lane copies its shift register into its own hold register. The hold registers are then pushed into one receive FIFO, primary first. The FIFO keeps the same storage but changes its shape with the word-length field: eight 16-bit entries for short words, or four 32-bit entries for long ones. The oldest entry is always visible on the read port. A read strobe removes it. Empty, full and a sticky overflow flag are reported.

Top module: `dual_serial_rx`

## Requirements
- R1: `cfg_wlen_i` holds the word length minus one. Values 0 and 1 are treated as 2. A field of 2 to 15 selects narrow mode, in which the FIFO holds 8 entries and `full_o` rises when the 8th is stored.
- R2: A field of 16 to 31 selects wide mode, in which the FIFO holds 4 entries of up to 32 bits and `full_o` rises when the 4th is stored.
- R3: Bits are sampled on the falling edge of the bit clock, most significant bit first. A word's first bit is the one sampled while frame sync is high. Frame sync seen while a word is in progress is ignored.
- R4: Each word appears on `rx_data_o` right-justified, with all bits above the word length zero.
- R5: A completed frame pushes the primary word and then the secondary word. With `cfg_sec_en_i` low, only the primary word is pushed.
- R6: If frame sync is high at the sample edge right after a word's last bit, the next word starts there, with no idle bit between the words.
- R7: `rx_data_o` shows the oldest entry while `empty_o` is low. `rd_i` removes that entry. `rd_i` while the FIFO is empty has no effect.
- R8: A push into a full FIFO is discarded and leaves the stored entries unchanged. It sets `ovf_o`, which stays high until it is cleared.
- R9: A one-cycle pulse on `ovf_clr_i` clears `ovf_o`. If an overflow happens in the same cycle, the set wins.
- R10: A change of `cfg_wlen_i` that moves the block between narrow and wide mode empties the FIFO.
- R11: With `cfg_int_clk_i` high, `sclk_oe_o` is high and `sclk_o` toggles every `cfg_clkdiv_i`+1 system clocks. With it low, `sclk_oe_o` is low, `sclk_o` stays low and `sclk_i` is used.
- R12: With `cfg_int_fs_i` high, `fs_oe_o` is high and `fs_o` is high for the first bit of every word, including the first bit after reset. Words then follow each other back to back.
- R13: After reset, `empty_o` is 1, while `full_o`, `ovf_o`, `sclk_o` and both output enables are 0 when the external sources are selected.
- R14: Bit periods that are sampled with frame sync low while no word is in progress store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wlen_i | input | 5 | Word length minus one |
| cfg_int_clk_i | input | 1 | 1: generate the bit clock internally |
| cfg_clkdiv_i | input | 8 | Half-period of the internal bit clock, minus one, in system clocks |
| cfg_int_fs_i | input | 1 | 1: generate frame sync internally |
| cfg_sec_en_i | input | 1 | Enable pushing of the secondary lane |
| sclk_i | input | 1 | External bit clock |
| sclk_o | output | 1 | Internal bit clock |
| sclk_oe_o | output | 1 | Output enable for the bit clock pin |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Internal frame sync |
| fs_oe_o | output | 1 | Output enable for the frame sync pin |
| dpri_i | input | 1 | Primary serial data |
| dsec_i | input | 1 | Secondary serial data |
| rd_i | input | 1 | Remove the oldest FIFO entry |
| rx_data_o | output | 32 | Oldest FIFO entry |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clear the overflow flag |

## Verification
The hardest case to reach from the ports is an overflow that must leave the stored entries intact. The FIFO only fills through whole serial frames, and each frame costs dozens of system clocks. The bench therefore sends exactly enough two-lane frames to fill each FIFO shape. It then sends one more frame and drains every entry, comparing each one with the values it sent before the overflow. The internal-clock case is equally indirect: the bench has to follow the generated clock and frame sync and place every bit on the rising edge before that bit is sampled.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned WLEN_MIN = 2;
  localparam int unsigned NLANES   = 2;

  typedef enum logic [1:0] {
    SIG_FS  = 2'd0,
    SIG_PRI = 2'd1,
    SIG_SEC = 2'd2
  } sig_idx_e;

  function automatic logic [4:0] clamp_wlen(input logic [4:0] f);
    return (f < 5'(WLEN_MIN)) ? 5'(WLEN_MIN) : f;
  endfunction
endpackage

// File: rtl/dsr_bitclk.sv
module dsr_bitclk #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NSIG        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_clk_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_i,
  input  logic [NSIG-1:0]  sig_i,
  output logic             sclk_o,
  output logic             smp_o,
  output logic [NSIG-1:0]  sig_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [DIV_W-1:0] div_cnt;
  logic             sclk_q;
  logic [NSIG:0]    stg [SYNC_STAGES];
  logic             clk_prev;
  logic [NSIG:0]    raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (!int_clk_i) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (div_cnt == div_i) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  // clock rides the same synchronizer as the data so both keep alignment
  assign raw    = {sig_i, int_clk_i ? sclk_q : sclk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
      clk_prev <= 1'b0;
    end else begin
      stg[0] <= raw;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      clk_prev <= stg[LAST][0];
    end
  end

  assign smp_o = clk_prev & ~stg[LAST][0];
  assign sig_o = stg[LAST][NSIG:1];
endmodule

// File: rtl/dsr_lane.sv
module dsr_lane #(
  parameter int unsigned MAX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             bit_i,
  output logic [MAX_W-1:0] hold_o
);
  logic [MAX_W-1:0] sreg, sreg_nxt;

  always_comb begin
    if (start_i) sreg_nxt = {{(MAX_W-1){1'b0}}, bit_i};
    else         sreg_nxt = {sreg[MAX_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg   <= '0;
      hold_o <= '0;
    end else begin
      if (shift_i) sreg <= sreg_nxt;
      if (done_i)  hold_o <= sreg_nxt;
    end
  end
endmodule

// File: rtl/dsr_fifo.sv
module dsr_fifo #(
  parameter int unsigned MAX_W        = 32,
  parameter int unsigned NARROW_W     = 16,
  parameter int unsigned NARROW_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [MAX_W-1:0] wdata_i,
  input  logic             pop_i,
  output logic [MAX_W-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             drop_o
);
  localparam int unsigned RATIO      = MAX_W / NARROW_W;
  localparam int unsigned WIDE_DEPTH = NARROW_DEPTH / RATIO;
  localparam int unsigned PTR_W      = $clog2(NARROW_DEPTH);
  localparam int unsigned CNT_W      = $clog2(NARROW_DEPTH + 1);

  logic [NARROW_W-1:0] mem [NARROW_DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    count, depth;
  logic                push_ok, pop_ok;

  assign depth   = wide_i ? CNT_W'(WIDE_DEPTH) : CNT_W'(NARROW_DEPTH);
  assign full_o  = (count == depth);
  assign empty_o = (count == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign drop_o  = push_i & full_o & ~flush_i;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] d);
    return (CNT_W'(p) == d - 1'b1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr, depth);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr, depth);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      if (wide_i) begin
        for (int k = 0; k < RATIO; k++)
          mem[PTR_W'(int'(wr_ptr) * RATIO + k)] <= wdata_i[k*NARROW_W +: NARROW_W];
      end else begin
        mem[wr_ptr] <= wdata_i[NARROW_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (wide_i) begin
      for (int k = 0; k < RATIO; k++)
        rdata_o[k*NARROW_W +: NARROW_W] = mem[PTR_W'(int'(rd_ptr) * RATIO + k)];
    end else begin
      rdata_o[NARROW_W-1:0] = mem[rd_ptr];
    end
  end
endmodule

// File: rtl/dual_serial_rx.sv
module dual_serial_rx #(
  parameter int unsigned MAX_W        = 32,
  parameter int unsigned NARROW_W     = 16,
  parameter int unsigned NARROW_DEPTH = 8,
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(MAX_W)-1:0]   cfg_wlen_i,
  input  logic                       cfg_int_clk_i,
  input  logic [DIV_W-1:0]           cfg_clkdiv_i,
  input  logic                       cfg_int_fs_i,
  input  logic                       cfg_sec_en_i,
  input  logic                       sclk_i,
  output logic                       sclk_o,
  output logic                       sclk_oe_o,
  input  logic                       fs_i,
  output logic                       fs_o,
  output logic                       fs_oe_o,
  input  logic                       dpri_i,
  input  logic                       dsec_i,
  input  logic                       rd_i,
  output logic [MAX_W-1:0]           rx_data_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       ovf_o,
  input  logic                       ovf_clr_i
);
  import dsr_pkg::*;

  localparam int unsigned WLEN_W = $clog2(MAX_W);
  localparam int unsigned NSIG   = NLANES + 1;

  logic [NSIG-1:0]   sig_s;
  logic              smp;
  logic [WLEN_W-1:0] wlen_eff;
  logic              wide, wide_q, flush;
  logic              active;
  logic [WLEN_W-1:0] bit_cnt, fs_cnt;
  logic              fs_gen, fs_sel;
  logic              lane_shift, lane_start, lane_done;
  logic [MAX_W-1:0]  hold [NLANES];
  logic [NLANES-1:0] pend;
  logic              push;
  logic [MAX_W-1:0]  push_data;
  logic              fifo_drop;

  assign wlen_eff = WLEN_W'(clamp_wlen(5'(cfg_wlen_i)));
  assign wide     = (wlen_eff >= WLEN_W'(NARROW_W));

  dsr_bitclk #(
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES),
    .NSIG       (NSIG)
  ) u_bitclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .int_clk_i(cfg_int_clk_i),
    .div_i    (cfg_clkdiv_i),
    .sclk_i   (sclk_i),
    .sig_i    ({dsec_i, dpri_i, fs_i}),
    .sclk_o   (sclk_o),
    .smp_o    (smp),
    .sig_o    (sig_s)
  );

  assign sclk_oe_o = cfg_int_clk_i;

  // internal frame sync: high for the first bit of each word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  fs_cnt <= '0;
    else if (!cfg_int_fs_i)       fs_cnt <= '0;
    else if (smp)                 fs_cnt <= (fs_cnt == wlen_eff) ? '0 : fs_cnt + 1'b1;
  end

  assign fs_gen  = (fs_cnt == '0);
  assign fs_o    = cfg_int_fs_i & fs_gen;
  assign fs_oe_o = cfg_int_fs_i;
  assign fs_sel  = cfg_int_fs_i ? fs_gen : sig_s[SIG_FS];

  // framer
  assign lane_start = ~active;
  assign lane_shift = smp & (active | fs_sel);
  assign lane_done  = smp & active & (bit_cnt == wlen_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active  <= 1'b0;
      bit_cnt <= '0;
    end else if (smp) begin
      if (!active) begin
        if (fs_sel) begin
          active  <= 1'b1;
          bit_cnt <= WLEN_W'(1);
        end
      end else if (bit_cnt == wlen_eff) begin
        active  <= 1'b0;
        bit_cnt <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    dsr_lane #(.MAX_W(MAX_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(lane_shift),
      .start_i(lane_start),
      .done_i (lane_done),
      .bit_i  (sig_s[g+1]),
      .hold_o (hold[g])
    );
  end

  // push sequencer: primary first, then secondary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= '0;
    end else if (lane_done) begin
      pend <= {cfg_sec_en_i, 1'b1};
    end else if (pend[0]) begin
      pend[0] <= 1'b0;
    end else if (pend[1]) begin
      pend[1] <= 1'b0;
    end
  end

  assign push      = |pend;
  assign push_data = pend[0] ? hold[0] : hold[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wide_q <= 1'b0;
    else         wide_q <= wide;
  end

  assign flush = (wide != wide_q);

  dsr_fifo #(
    .MAX_W       (MAX_W),
    .NARROW_W    (NARROW_W),
    .NARROW_DEPTH(NARROW_DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wide_i (wide),
    .flush_i(flush),
    .push_i (push),
    .wdata_i(push_data),
    .pop_i  (rd_i),
    .rdata_o(rx_data_o),
    .empty_o(empty_o),
    .full_o (full_o),
    .drop_o (fifo_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (fifo_drop) ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ovf_o,
  input logic ovf_clr_i,
  input logic drop_i,
  input logic empty_o,
  input logic full_o,
  input logic push_i,
  input logic rd_i,
  input logic flush_i,
  input logic sclk_o,
  input logic cfg_int_clk_i
);
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o); // R8
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovf_o); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !drop_i |=> !ovf_o); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R7
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !push_i |=> empty_o); // R7
  AST_FULL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_i && !flush_i |=> full_o); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R10
  AST_SCLK_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_int_clk_i |=> !sclk_o); // R11
endmodule

bind dual_serial_rx dsr_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ovf_o        (ovf_o),
  .ovf_clr_i    (ovf_clr_i),
  .drop_i       (fifo_drop),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .push_i       (push),
  .rd_i         (rd_i),
  .flush_i      (flush),
  .sclk_o       (sclk_o),
  .cfg_int_clk_i(cfg_int_clk_i)
);

// File: tb/dual_serial_rx_test.sv
module dual_serial_rx_test;
  localparam int H = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  cfg_wlen_i = 5'd11;
  logic        cfg_int_clk_i = 1'b0;
  logic [7:0]  cfg_clkdiv_i = 8'd5;
  logic        cfg_int_fs_i = 1'b0;
  logic        cfg_sec_en_i = 1'b1;
  logic        sclk_i = 1'b0, fs_i = 1'b0, dpri_i = 1'b0, dsec_i = 1'b0;
  logic        rd_i = 1'b0, ovf_clr_i = 1'b0;
  logic        sclk_o, sclk_oe_o, fs_o, fs_oe_o, empty_o, full_o, ovf_o;
  logic [31:0] rx_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  dual_serial_rx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wlen_i(cfg_wlen_i),
    .cfg_int_clk_i(cfg_int_clk_i), .cfg_clkdiv_i(cfg_clkdiv_i),
    .cfg_int_fs_i(cfg_int_fs_i), .cfg_sec_en_i(cfg_sec_en_i),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .fs_i(fs_i), .fs_o(fs_o), .fs_oe_o(fs_oe_o),
    .dpri_i(dpri_i), .dsec_i(dsec_i), .rd_i(rd_i),
    .rx_data_o(rx_data_o), .empty_o(empty_o), .full_o(full_o),
    .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] wl, input logic sec, input logic ic, input logic ifs);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_wlen_i = wl; cfg_sec_en_i = sec; cfg_int_clk_i = ic; cfg_int_fs_i = ifs;
    sclk_i = 0; fs_i = 0; dpri_i = 0; dsec_i = 0; rd_i = 0; ovf_clr_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_i);
  endtask

  function automatic logic [31:0] msk(input int n, input logic [31:0] w);
    return (n >= 32) ? w : (w & ((32'h1 << n) - 1));
  endfunction

  // rising edge drives, falling edge samples
  task automatic ext_bit(input logic f, input logic p, input logic s);
    @(negedge clk_i);
    sclk_i = 1; fs_i = f; dpri_i = p; dsec_i = s;
    repeat (H) @(negedge clk_i);
    sclk_i = 0;
    repeat (H) @(negedge clk_i);
  endtask

  task automatic ext_word(input int n, input logic [31:0] p, input logic [31:0] s, input bit mid_fs);
    for (int i = n - 1; i >= 0; i--)
      ext_bit((i == n - 1) || (mid_fs && i == n - 3), p[i], s[i]);
    fs_i = 0;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    @(negedge clk_i);
    check({req, " not empty"}, {31'b0, empty_o}, 32'd0);
    check(req, rx_data_o, exp);
    rd_i = 1;
    @(negedge clk_i);
    rd_i = 0;
  endtask

  task automatic t_reset();
    do_reset(5'd11, 1, 0, 0);
    @(negedge clk_i);
    check("R13 empty", {31'b0, empty_o}, 32'd1);
    check("R13 full", {31'b0, full_o}, 32'd0);
    check("R13 ovf", {31'b0, ovf_o}, 32'd0);
    check("R13 R11 sclk_o/oe", {30'b0, sclk_o, sclk_oe_o}, 32'd0);
    check("R13 fs_oe", {31'b0, fs_oe_o}, 32'd0);
  endtask

  task automatic t_no_fs();
    do_reset(5'd7, 1, 0, 0);
    for (int i = 0; i < 10; i++) ext_bit(0, 1, 1);
    settle();
    check("R14 no frame stored", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_basic();
    do_reset(5'd11, 1, 0, 0);
    ext_word(12, 32'hA5C, 32'h3F1, 1);
    settle();
    pop_chk("R3 R4 R5 primary", 32'h00000A5C);
    pop_chk("R5 secondary", 32'h000003F1);
    check("R7 empty after reads", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_sec_off();
    do_reset(5'd9, 0, 0, 0);
    ext_word(10, 32'h2B7, 32'h3FF, 0);
    settle();
    pop_chk("R5 primary only", 32'h2B7);
    check("R5 secondary not pushed", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_b2b();
    do_reset(5'd4, 1, 0, 0);
    ext_word(5, 32'h15, 32'h0A, 0);
    ext_word(5, 32'h1E, 32'h03, 0);
    settle();
    pop_chk("R6 w0 pri", 32'h15);
    pop_chk("R6 w0 sec", 32'h0A);
    pop_chk("R6 w1 pri", 32'h1E);
    pop_chk("R6 w1 sec", 32'h03);
  endtask

  task automatic t_empty_read();
    do_reset(5'd7, 0, 0, 0);
    @(negedge clk_i); rd_i = 1; @(negedge clk_i); rd_i = 0;
    ext_word(8, 32'hC3, 32'h0, 0);
    settle();
    pop_chk("R7 read of empty ignored", 32'hC3);
    check("R7 empty again", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_short_clamp();
    do_reset(5'd0, 0, 0, 0);
    ext_word(3, 32'h5, 32'h0, 0);
    settle();
    pop_chk("R1 field 0 gives 3-bit word", 32'h5);
  endtask

  task automatic t_narrow_fill();
    logic [31:0] pv [4];
    logic [31:0] sv [4];
    do_reset(5'd7, 1, 0, 0);
    for (int f = 0; f < 4; f++) begin
      pv[f] = 32'h11 * (f + 1) + 32'h80;
      sv[f] = 32'h0F + 32'h20 * f;
      ext_word(8, pv[f], sv[f], 0);
    end
    settle();
    check("R1 full after 8", {31'b0, full_o}, 32'd1);
    check("R8 no ovf yet", {31'b0, ovf_o}, 32'd0);
    ext_word(8, 32'hFF, 32'hEE, 0);
    settle();
    check("R8 ovf set", {31'b0, ovf_o}, 32'd1);
    for (int f = 0; f < 4; f++) begin
      pop_chk("R8 narrow pri kept", msk(8, pv[f]));
      pop_chk("R8 narrow sec kept", msk(8, sv[f]));
    end
    check("R8 dropped words absent", {31'b0, empty_o}, 32'd1);
    check("R8 ovf sticky", {31'b0, ovf_o}, 32'd1);
    @(negedge clk_i); ovf_clr_i = 1; @(negedge clk_i); ovf_clr_i = 0;
    @(negedge clk_i);
    check("R9 ovf cleared", {31'b0, ovf_o}, 32'd0);
  endtask

  task automatic t_wide_fill();
    do_reset(5'd23, 1, 0, 0);
    ext_word(24, 32'hABCDEF, 32'h123456, 0);
    settle();
    check("R2 not full at 2", {31'b0, full_o}, 32'd0);
    ext_word(24, 32'h800001, 32'h7F00FF, 0);
    settle();
    check("R2 full after 4", {31'b0, full_o}, 32'd1);
    ext_word(24, 32'h555555, 32'hAAAAAA, 0);
    settle();
    check("R8 wide ovf", {31'b0, ovf_o}, 32'd1);
    pop_chk("R4 wide right-justified", 32'h00ABCDEF);
    pop_chk("R2 wide sec", 32'h00123456);
    pop_chk("R2 wide pri2", 32'h00800001);
    pop_chk("R2 wide sec2", 32'h007F00FF);
    check("R8 wide dropped absent", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_full32();
    do_reset(5'd31, 0, 0, 0);
    ext_word(32, 32'hDEADBEEF, 32'h0, 0);
    settle();
    pop_chk("R2 32-bit word", 32'hDEADBEEF);
  endtask

  task automatic t_flush();
    do_reset(5'd11, 1, 0, 0);
    ext_word(12, 32'h123, 32'h456, 0);
    settle();
    check("R10 filled", {31'b0, empty_o}, 32'd0);
    cfg_wlen_i = 5'd13;
    repeat (3) @(negedge clk_i);
    check("R10 same mode keeps", {31'b0, empty_o}, 32'd0);
    cfg_wlen_i = 5'd20;
    repeat (3) @(negedge clk_i);
    check("R10 mode change empties", {31'b0, empty_o}, 32'd1);
  endtask

  task automatic t_internal();
    logic [7:0] pw [2];
    logic [7:0] sw [2];
    int hi;
    pw[0] = 8'h9C; pw[1] = 8'h47; sw[0] = 8'h31; sw[1] = 8'hE8;
    cfg_clkdiv_i = 8'd5;
    do_reset(5'd7, 1, 1, 1);
    @(negedge clk_i);
    check("R11 sclk_oe", {31'b0, sclk_oe_o}, 32'd1);
    check("R12 fs_oe", {31'b0, fs_oe_o}, 32'd1);
    for (int b = 0; b < 16; b++) begin
      @(posedge sclk_o);
      #1;
      check("R12 fs_o on first bit", {31'b0, fs_o}, {31'b0, (b % 8) == 0});
      dpri_i = pw[b / 8][7 - (b % 8)];
      dsec_i = sw[b / 8][7 - (b % 8)];
    end
    hi = 0;
    @(posedge sclk_o);
    dpri_i = 0; dsec_i = 0;
    while (sclk_o) begin
      @(negedge clk_i);
      if (sclk_o) hi++;
    end
    check("R11 half period", hi, 6);
    cfg_int_clk_i = 0; cfg_int_fs_i = 0;
    settle();
    pop_chk("R12 internal w0 pri", 32'h9C);
    pop_chk("R12 internal w0 sec", 32'h31);
    pop_chk("R12 internal w1 pri", 32'h47);
    pop_chk("R12 internal w1 sec", 32'hE8);
    check("R12 nothing extra", {31'b0, empty_o}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_no_fs();
    t_basic();
    t_sec_off();
    t_b2b();
    t_empty_read();
    t_short_clamp();
    t_narrow_fill();
    t_wide_fill();
    t_full32();
    t_flush();
    t_internal();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule